// File: doc/BRIEF.md
# RTC Event Flags and Interrupt Unit

This block keeps time of day and a running day count. A one-pulse-per-second tick input advances it. Every timekeeping event is recorded in a 32-bit status word: a new second, a minute carry, an hour carry, a day carry, an alarm hit and a stopwatch timeout. A single interrupt request is raised for any recorded event whose enable bit is set. An event sets its status flag even when its enable bit is clear, so software can poll flags it has not enabled. Software clears a flag by writing a one to its bit, and that also removes the interrupt the flag caused.

The alarm compares the full time against a programmed day, hour, minute and second. The day count is 16 bits wide, so an alarm that stays enabled fires again every 65536 days. The stopwatch is a down-counter loaded from the register bus. It counts minute carries, flags once when it reaches zero and then holds. All state is reached through a small word-addressed bus. A write takes effect at the clock edge where the write strobe is sampled. Reads are combinational on the address.

Top module: `rtc_event_unit`

## Requirements
- R1: The status word (address 0) places its flags as follows: bit 0 stopwatch timeout, bit 1 minute carry, bit 2 alarm, bit 3 day carry, bit 4 second, bit 5 hour carry. Bits 31..6 read as zero, and writing ones to them changes nothing.
- R2: An event sets its status bit whatever the value of its enable bit at address 1, bits 5..0, laid out the same way as the status bits.
- R3: Writing to the status word clears every bit written as one and leaves every bit written as zero unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends set.
- R4: `irq` is high exactly when some status bit and its enable bit are both one.
- R5: On each tick that is taken, seconds advance 0..59 and carry into minutes 0..59. Minutes carry into hours 0..23, and hours carry into a 16-bit day count that wraps from 65535 to 0.
- R6: Every tick that is taken sets the second flag. A seconds wrap sets the minute flag, and a minutes wrap that carries into the hours sets the hour flag.
- R7: An hours wrap from 23 to 0 increments the day count and sets the day flag.
- R8: On a tick that is taken, the alarm flag sets when the new day, hour, minute and second all equal the alarm registers. The alarm time of day is at address 4 and the alarm day is at address 5, bits 15..0. A bus write to the time never raises the alarm.
- R9: Writing N to address 6 loads the stopwatch, which runs when N is nonzero. Each minute carry while running decrements it. When it goes from 1 to 0 it sets the stopwatch flag once and stops. A load in the same cycle as a minute carry takes priority over the decrement.
- R10: The time of day sits at address 2, with seconds in bits 5..0, minutes in bits 13..8 and hours in bits 20..16. The day count sits at address 3, bits 15..0. A written field that is out of range loads 0. A tick in the same cycle as a write to address 2 or 3 is dropped.
- R11: After a synchronous active-low reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address presented |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a second event that sets a status bit while software writes a one to clear that same bit. The second pair is a tick that arrives while a time write is in progress. The bench drives both inputs together in a single cycle for each case. It expects the flag to stay set in the first case and the tick to be dropped in the second. A behavioural reference model checks every cycle, including a long random phase that mixes ticks, clear writes, enable writes and stopwatch loads, and compares the read data and the interrupt line.

// File: rtl/rtc_evt_pkg.sv
// Shared constants, register addresses and the time-of-day type.
// Assumes a 32-bit register bus with word addresses.
package rtc_evt_pkg;

    localparam int NUM_EVT = 6;
    localparam int EV_SW   = 0;
    localparam int EV_MIN  = 1;
    localparam int EV_ALM  = 2;
    localparam int EV_DAY  = 3;
    localparam int EV_SEC  = 4;
    localparam int EV_HR   = 5;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS  = 3'd0,
        RA_ENABLE  = 3'd1,
        RA_TOD     = 3'd2,
        RA_DAY     = 3'd3,
        RA_ALM_TOD = 3'd4,
        RA_ALM_DAY = 3'd5,
        RA_SWATCH  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    // Build a time of day from bus fields, forcing out-of-range fields to zero.
    function automatic tod_t make_tod(logic [4:0] h, logic [5:0] m, logic [5:0] s);
        tod_t t;
        t.hr  = (h > 5'd23) ? 5'd0 : h;
        t.min = (m > 6'd59) ? 6'd0 : m;
        t.sec = (s > 6'd59) ? 6'd0 : s;
        return t;
    endfunction

    // Place a time of day in its read-back word layout.
    function automatic logic [31:0] pack_tod(tod_t t);
        return {11'b0, t.hr, 2'b0, t.min, 2'b0, t.sec};
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
// Seconds, minutes, hours and day counters advanced by the 1 Hz tick.
// Emits one-cycle event pulses and the next time value for the alarm compare.
// Assumes tick is a single-cycle pulse; a bus write to the time drops a coincident tick.
module rtc_time_core
    import rtc_evt_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tod_wr,
    input  logic             day_wr,
    input  tod_t             tod_wdata,
    input  logic [DAY_W-1:0] day_wdata,
    output tod_t             tod_q,
    output logic [DAY_W-1:0] day_q,
    output tod_t             nxt_tod,
    output logic [DAY_W-1:0] nxt_day,
    output logic             step,
    output logic             sec_evt,
    output logic             min_evt,
    output logic             hr_evt,
    output logic             day_evt
);

    localparam logic [DAY_W-1:0] DAY_ONE = {{(DAY_W-1){1'b0}}, 1'b1};

    logic sec_wrap, min_wrap, hr_wrap;

    // Carry chain and next-time computation.
    always_comb begin
        step     = tick & ~tod_wr & ~day_wr;
        sec_wrap = (tod_q.sec == 6'd59);
        min_wrap = sec_wrap && (tod_q.min == 6'd59);
        hr_wrap  = min_wrap && (tod_q.hr == 5'd23);
        nxt_tod.sec = sec_wrap ? 6'd0 : tod_q.sec + 6'd1;
        nxt_tod.min = !sec_wrap ? tod_q.min : (tod_q.min == 6'd59) ? 6'd0 : tod_q.min + 6'd1;
        nxt_tod.hr  = !min_wrap ? tod_q.hr : (tod_q.hr == 5'd23) ? 5'd0 : tod_q.hr + 5'd1;
        nxt_day     = hr_wrap ? day_q + DAY_ONE : day_q;
        sec_evt = step;
        min_evt = step & sec_wrap;
        hr_evt  = step & min_wrap;
        day_evt = step & hr_wrap;
    end

    // Time registers: bus writes load, otherwise a taken tick advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q <= '0;
            day_q <= '0;
        end else begin
            if (tod_wr) tod_q <= tod_wdata;
            if (day_wr) day_q <= day_wdata;
            if (step) begin
                tod_q <= nxt_tod;
                day_q <= nxt_day;
            end
        end
    end

    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_q.sec <= 6'd59) && (tod_q.min <= 6'd59) && (tod_q.hr <= 5'd23));

    p_min_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        min_evt |=> (tod_q.sec == 6'd0));

    p_day_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        day_evt |=> (day_q == $past(day_q) + DAY_ONE) && (tod_q == '0));

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Alarm registers and the match against the time about to be loaded.
// Assumes the match is only meaningful on a taken tick (step).
module rtc_alarm_cmp
    import rtc_evt_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tod_wr,
    input  logic             day_wr,
    input  tod_t             tod_wdata,
    input  logic [DAY_W-1:0] day_wdata,
    input  logic             step,
    input  tod_t             nxt_tod,
    input  logic [DAY_W-1:0] nxt_day,
    input  tod_t             cur_tod,
    input  logic [DAY_W-1:0] cur_day,
    output tod_t             alm_tod_q,
    output logic [DAY_W-1:0] alm_day_q,
    output logic             alm_evt
);

    // Alarm target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_tod_q <= '0;
            alm_day_q <= '0;
        end else begin
            if (tod_wr) alm_tod_q <= tod_wdata;
            if (day_wr) alm_day_q <= day_wdata;
        end
    end

    // Match fires when the time being entered equals the target.
    always_comb begin
        alm_evt = step && (nxt_tod == alm_tod_q) && (nxt_day == alm_day_q);
    end

    p_alarm_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_evt && !tod_wr && !day_wr) |=> (cur_tod == alm_tod_q) && (cur_day == alm_day_q));

endmodule

// File: rtl/rtc_stopwatch.sv
// Minute-based countdown; flags once on reaching zero, then holds until reloaded.
// Assumes a load has priority over a coincident minute decrement.
module rtc_stopwatch #(
    parameter int SW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SW_W-1:0] load_val,
    input  logic            min_evt,
    output logic [SW_W-1:0] cnt_q,
    output logic            run_q,
    output logic            sw_evt
);

    localparam logic [SW_W-1:0] SW_ONE = {{(SW_W-1){1'b0}}, 1'b1};

    // Timeout pulse on the last decrement.
    always_comb begin
        sw_evt = !load && run_q && min_evt && (cnt_q == SW_ONE);
    end

    // Count and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= (load_val != '0);
        end else if (run_q && min_evt) begin
            cnt_q <= cnt_q - SW_ONE;
            if (cnt_q == SW_ONE) run_q <= 1'b0;
        end
    end

    p_sw_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> (!run_q && (cnt_q == '0)));

    p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_irq_status.sv
// Sticky event flags with write-one-to-clear, the enable mask and the interrupt OR.
// Assumes a set from an event wins over a clear in the same cycle.
module rtc_irq_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] sts_q,
    output logic [N-1:0] en_q,
    output logic         irq
);

    logic [N-1:0] clr_bits;

    // Bits to clear this cycle.
    always_comb begin
        clr_bits = clr_wr ? clr_mask : '0;
    end

    // Status flags: clear first, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_bits) | evt;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    // Interrupt request from enabled flags.
    always_comb begin
        irq = |(sts_q & en_q);
    end

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((sts_q & $past(clr_mask) & ~$past(evt)) == '0));

    p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt) || $past(en_wr)));

endmodule

// File: rtl/rtc_event_unit.sv
// Top: register decode, time core, alarm, stopwatch and status/interrupt unit.
// Assumes word-addressed writes sampled at the clock edge; reads are combinational.
module rtc_event_unit
    import rtc_evt_pkg::*;
#(
    parameter int DAY_W = 16,
    parameter int SW_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    logic wr_sts, wr_en, wr_tod, wr_day, wr_atod, wr_aday, wr_sw;
    tod_t             wr_tod_val;
    logic [DAY_W-1:0] wr_day_val;
    tod_t             tod_q, nxt_tod, alm_tod_q;
    logic [DAY_W-1:0] day_q, nxt_day, alm_day_q;
    logic             step, sec_evt, min_evt, hr_evt, day_evt, alm_evt, sw_evt;
    logic [SW_W-1:0]  sw_cnt;
    logic             sw_run;
    logic [NUM_EVT-1:0] evt, sts_q, en_q;
    logic unused_wdata;

    // Write decode and field extraction.
    always_comb begin
        wr_sts  = bus_wr && (bus_addr == RA_STATUS);
        wr_en   = bus_wr && (bus_addr == RA_ENABLE);
        wr_tod  = bus_wr && (bus_addr == RA_TOD);
        wr_day  = bus_wr && (bus_addr == RA_DAY);
        wr_atod = bus_wr && (bus_addr == RA_ALM_TOD);
        wr_aday = bus_wr && (bus_addr == RA_ALM_DAY);
        wr_sw   = bus_wr && (bus_addr == RA_SWATCH);
        wr_tod_val = make_tod(bus_wdata[20:16], bus_wdata[13:8], bus_wdata[5:0]);
        wr_day_val = bus_wdata[DAY_W-1:0];
    end

    assign unused_wdata = ^bus_wdata[31:21];

    rtc_time_core #(.DAY_W(DAY_W)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
        .tod_wr(wr_tod), .day_wr(wr_day),
        .tod_wdata(wr_tod_val), .day_wdata(wr_day_val),
        .tod_q(tod_q), .day_q(day_q), .nxt_tod(nxt_tod), .nxt_day(nxt_day),
        .step(step), .sec_evt(sec_evt), .min_evt(min_evt),
        .hr_evt(hr_evt), .day_evt(day_evt)
    );

    rtc_alarm_cmp #(.DAY_W(DAY_W)) u_alarm (
        .clk(clk), .rst_n(rst_n),
        .tod_wr(wr_atod), .day_wr(wr_aday),
        .tod_wdata(wr_tod_val), .day_wdata(wr_day_val),
        .step(step), .nxt_tod(nxt_tod), .nxt_day(nxt_day),
        .cur_tod(tod_q), .cur_day(day_q),
        .alm_tod_q(alm_tod_q), .alm_day_q(alm_day_q), .alm_evt(alm_evt)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_swatch (
        .clk(clk), .rst_n(rst_n), .load(wr_sw),
        .load_val(bus_wdata[SW_W-1:0]), .min_evt(min_evt),
        .cnt_q(sw_cnt), .run_q(sw_run), .sw_evt(sw_evt)
    );

    // Gather event pulses into status bit positions.
    always_comb begin
        evt         = '0;
        evt[EV_SW]  = sw_evt;
        evt[EV_MIN] = min_evt;
        evt[EV_ALM] = alm_evt;
        evt[EV_DAY] = day_evt;
        evt[EV_SEC] = sec_evt;
        evt[EV_HR]  = hr_evt;
    end

    rtc_irq_status #(.N(NUM_EVT)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .clr_wr(wr_sts), .clr_mask(bus_wdata[NUM_EVT-1:0]),
        .en_wr(wr_en), .en_wdata(bus_wdata[NUM_EVT-1:0]),
        .sts_q(sts_q), .en_q(en_q), .irq(irq)
    );

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            RA_STATUS:  bus_rdata = 32'(sts_q);
            RA_ENABLE:  bus_rdata = 32'(en_q);
            RA_TOD:     bus_rdata = pack_tod(tod_q);
            RA_DAY:     bus_rdata = 32'(day_q);
            RA_ALM_TOD: bus_rdata = pack_tod(alm_tod_q);
            RA_ALM_DAY: bus_rdata = 32'(alm_day_q);
            RA_SWATCH:  bus_rdata = 32'(sw_cnt);
            default:    bus_rdata = '0;
        endcase
    end

    p_sw_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |-> sw_run);

endmodule

// File: tb/rtc_event_unit_bench.sv
`timescale 1ns/1ps
module rtc_event_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int m_sec, m_min, m_hr, m_day, m_asec, m_amin, m_ahr, m_aday, m_sw, m_run, m_sts, m_en;

    always #2.5 clk = ~clk;

    rtc_event_unit u_rtc_event_unit (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int clampf(int v, int mx);
        return (v > mx) ? 0 : v;
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return m_sts;
            1: return m_en;
            2: return (m_hr << 16) | (m_min << 8) | m_sec;
            3: return m_day;
            4: return (m_ahr << 16) | (m_amin << 8) | m_asec;
            5: return m_aday;
            6: return m_sw;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int ev, ns, nm, nh, nd, clr, a, d;
        bit twr;
        a = int'(bus_addr);
        d = int'(bus_wdata);
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 0;
            m_asec = 0; m_amin = 0; m_ahr = 0; m_aday = 0;
            m_sw = 0; m_run = 0; m_sts = 0; m_en = 0;
            return;
        end
        ev = 0;
        twr = bus_wr && (a == 2 || a == 3);
        if (tick_1hz && !twr) begin
            ns = m_sec + 1; nm = m_min; nh = m_hr; nd = m_day;
            ev = ev | 16;
            if (ns == 60) begin
                ns = 0; nm = nm + 1; ev = ev | 2;
                if (nm == 60) begin
                    nm = 0; nh = nh + 1; ev = ev | 32;
                    if (nh == 24) begin
                        nh = 0; nd = (nd + 1) % 65536; ev = ev | 8;
                    end
                end
            end
            if (ns == m_asec && nm == m_amin && nh == m_ahr && nd == m_aday) ev = ev | 4;
            if ((ev & 2) != 0 && m_run != 0 && !(bus_wr && a == 6)) begin
                m_sw = m_sw - 1;
                if (m_sw == 0) begin ev = ev | 1; m_run = 0; end
            end
            m_sec = ns; m_min = nm; m_hr = nh; m_day = nd;
        end
        clr = (bus_wr && a == 0) ? (d & 63) : 0;
        m_sts = (m_sts & ~clr & 63) | ev;
        if (bus_wr) begin
            case (a)
                1: m_en = d & 63;
                2: begin
                    m_hr = clampf((d >> 16) & 31, 23);
                    m_min = clampf((d >> 8) & 63, 59);
                    m_sec = clampf(d & 63, 59);
                end
                3: m_day = d & 65535;
                4: begin
                    m_ahr = clampf((d >> 16) & 31, 23);
                    m_amin = clampf((d >> 8) & 63, 59);
                    m_asec = clampf(d & 63, 59);
                end
                5: m_aday = d & 65535;
                6: begin m_sw = d & 255; m_run = (m_sw != 0) ? 1 : 0; end
                default: ;
            endcase
        end
    endtask

    // Reference model advance and per-cycle comparison.
    always @(posedge clk) begin
        model_step();
        #1;
        tests++;
        if (bus_rdata !== 32'(model_read(int'(bus_addr)))) begin
            fails++;
            $display("FAIL R1/R5 model compare addr %0d actual=%h expected=%h",
                     bus_addr, bus_rdata, model_read(int'(bus_addr)));
        end
        tests++;
        if (irq !== ((m_sts & m_en) != 0)) begin
            fails++;
            $display("FAIL R4 model irq actual=%b expected=%b", irq, (m_sts & m_en) != 0);
        end
    end

    task automatic cyc(input bit w, input int a, input int d, input bit t);
        bus_wr = w; bus_addr = 3'(a); bus_wdata = 32'(d); tick_1hz = t;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 32'd0; tick_1hz = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        bus_addr = 3'(a);
        #1;
        tests++;
        if (bus_rdata !== 32'(exp)) begin
            fails++;
            $display("FAIL %s addr %0d actual=%h expected=%h", tag, a, bus_rdata, 32'(exp));
        end
        bus_addr = 3'd0;
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        tests++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        for (int a = 0; a < 8; a++) rd(a, 0, "R11");
        irq_chk(1'b0, "R11");
        // R2 flag without enable
        cyc(1, 1, 0, 0);
        cyc(0, 0, 0, 1);
        rd(0, 'h10, "R2");
        irq_chk(1'b0, "R4");
        rd(2, 1, "R5");
        // R3 write zero keeps, write one clears
        cyc(1, 0, 0, 0);
        rd(0, 'h10, "R3");
        cyc(1, 0, 'h10, 0);
        rd(0, 0, "R3");
        // R4 enabled interrupt
        cyc(1, 1, 'h10, 0);
        rd(1, 'h10, "R10");
        cyc(0, 0, 0, 1);
        irq_chk(1'b1, "R4");
        cyc(1, 0, 'h3F, 0);
        irq_chk(1'b0, "R4");
        // R6 minute carry
        cyc(1, 2, 59, 0);
        cyc(0, 0, 0, 1);
        rd(0, 'h12, "R6");
        rd(2, 'h100, "R6");
        cyc(1, 0, 'h3F, 0);
        // R6 hour carry
        cyc(1, 2, (59 << 8) | 59, 0);
        cyc(0, 0, 0, 1);
        rd(0, 'h32, "R6");
        rd(2, 1 << 16, "R6");
        cyc(1, 0, 'h3F, 0);
        // R7 day carry
        cyc(1, 3, 5, 0);
        cyc(1, 2, (23 << 16) | (59 << 8) | 59, 0);
        cyc(0, 0, 0, 1);
        rd(0, 'h3A, "R7");
        rd(3, 6, "R7");
        rd(2, 0, "R7");
        cyc(1, 0, 'h3F, 0);
        // R5 day wrap; lands on the reset alarm value, so R8 too
        cyc(1, 3, 65535, 0);
        cyc(1, 2, (23 << 16) | (59 << 8) | 59, 0);
        cyc(0, 0, 0, 1);
        rd(3, 0, "R5");
        rd(0, 'h3E, "R8");
        cyc(1, 0, 'h3F, 0);
        // R8 programmed alarm
        cyc(1, 5, 7, 0);
        cyc(1, 4, 2, 0);
        cyc(1, 3, 7, 0);
        cyc(1, 2, 0, 0);
        rd(0, 0, "R8");
        cyc(0, 0, 0, 1);
        rd(0, 'h10, "R8");
        cyc(0, 0, 0, 1);
        rd(0, 'h14, "R8");
        // R1 reserved bits ignore writes
        cyc(1, 0, 32'hFFFFFFC0, 0);
        rd(0, 'h14, "R1");
        cyc(1, 0, 'h3F, 0);
        // R3 set wins over clear
        cyc(1, 0, 'h10, 1);
        rd(0, 'h10, "R3");
        cyc(1, 0, 'h3F, 0);
        // R9 stopwatch
        cyc(1, 5, 100, 0);
        cyc(1, 6, 2, 0);
        rd(6, 2, "R9");
        cyc(1, 2, 59, 0);
        cyc(0, 0, 0, 1);
        rd(0, 'h12, "R9");
        rd(6, 1, "R9");
        cyc(1, 2, 59, 0);
        cyc(0, 0, 0, 1);
        rd(0, 'h13, "R9");
        rd(6, 0, "R9");
        cyc(1, 0, 'h3F, 0);
        cyc(1, 2, 59, 0);
        cyc(0, 0, 0, 1);
        rd(0, 'h12, "R9");
        cyc(1, 0, 'h3F, 0);
        // R10 tick dropped during a time write
        cyc(1, 2, 10, 1);
        rd(2, 10, "R10");
        rd(0, 0, "R10");
        // R10 out-of-range fields
        cyc(1, 2, (30 << 16) | (61 << 8) | 61, 0);
        rd(2, 0, "R10");
        cyc(1, 2, (12 << 16) | (61 << 8) | 5, 0);
        rd(2, 'h0C0005, "R10");
        // Random mix checked by the model every cycle
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 8)       cyc(1, 0, int'($urandom_range(0, 63)), $urandom_range(0, 1) == 1);
            else if (r < 12) cyc(1, 1, int'($urandom_range(0, 63)), $urandom_range(0, 1) == 1);
            else if (r < 14) cyc(1, 6, int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
            else if (r < 16) cyc(1, 2, (23 << 16) | (59 << 8) | int'($urandom_range(50, 59)), 0);
            else             cyc(0, 0, 0, $urandom_range(0, 1) == 1);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule